// File: doc/BRIEF.md
# Banked GPIO Data and Direction Port

This block is a memory-mapped general-purpose I/O port of up to a few banks of 32 pins, behind a simple single-cycle 32-bit register bus with an address, a write strobe, write data and registered read data. Software selects per pin whether it drives or listens and sets the level it drives. It reads back the level actually present on the pin.

Each bank owns a small register window. A direction register sets the role of each pin: a one makes it an input, a zero an output. An output latch holds the driven levels. It can be loaded whole, or changed bit by bit through a write-one-to-set port and a write-one-to-clear port, so that two agents can touch different pins without a read-modify-write. The input register shows each pin level after a two-flop synchroniser. It is valid whatever the pin's direction, so a driven output can be observed on the wire. The block drives the output latch and the output enables straight to the pad ring.

Top module: `gpio_bank_port`

## Requirements
- R1: While reset is held and on the first cycle after it, every direction bit reads 1, the output latch is 0, `pin_oe` and `pin_out` are all zero and `bus_rdata` is zero.
- R2: Bank n occupies byte addresses starting at 0x10 + 0x28*n, with registers at word offsets direction 0x00, latch 0x04, set 0x08, clear 0x0C and input 0x10. Pin p uses bank p/32, bit p%32.
- R3: `pin_oe[p]` is the inverse of direction bit p, and `pin_out[p]` equals latch bit p whatever the direction.
- R4: A write to the set offset ORs the write data into the latch; zero bits leave their latch bits unchanged.
- R5: A write to the clear offset clears the latch bits where the write data is 1; zero bits leave their latch bits unchanged.
- R6: A write to the latch offset loads it directly. Reads of the latch, set and clear offsets all return the current latch.
- R7: The input offset returns the pin levels through two synchronising flops. A pin change made before clock edge k first appears in `bus_rdata` after edge k+2 when that address is presented continuously, and the input reflects driven outputs too.
- R8: Addresses that are not one of the mapped offsets read as zero and writes to them change nothing. This covers gaps, the remaining words of each bank window, addresses past the last bank and unaligned addresses. A write to the input offset is also ignored.
- R9: `bus_rdata` is registered. It shows the addressed register one cycle after the address is presented, with the value held before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Registered read data |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Output latch levels to the pads |
| pin_oe | output | NUM_PINS | Pad output enables, high drives |

## Verification
The hardest case is the input path's timing. A pin change must stay invisible for exactly two edges and then appear, which only shows up when the read address is held while the pin moves. A directed sequence changes a single pin and samples three consecutive reads. Another subtle case is a write and a read of the same register in one cycle, which has to return the old value. Random stimulus then interleaves set, clear, load, direction and ignored writes with pin changes. Each change is followed by enough idle cycles for the synchroniser, so that a bench model of the latch, direction and pins can predict every readback.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WIN_BASE   = 16;
  localparam int WIN_STRIDE = 40;

  localparam int OFF_DIR = 0;
  localparam int OFF_LAT = 4;
  localparam int OFF_SET = 8;
  localparam int OFF_CLR = 12;
  localparam int OFF_INP = 16;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_LAT  = 3'd2,
    SEL_SET  = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_INP  = 3'd5
  } reg_sel_e;

  function automatic reg_sel_e off_to_sel(input int off);
    case (off)
      OFF_DIR: return SEL_DIR;
      OFF_LAT: return SEL_LAT;
      OFF_SET: return SEL_SET;
      OFF_CLR: return SEL_CLR;
      OFF_INP: return SEL_INP;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BIDX_W-1:0] bank,
  output reg_sel_e          sel
);

  always_comb begin
    hit  = 1'b0;
    bank = '0;
    sel  = SEL_NONE;
    for (int b = 0; b < NUM_BANKS; b++) begin
      int off;
      off = int'(addr) - (WIN_BASE + WIN_STRIDE * b);
      if (off >= 0 && off <= OFF_INP && off_to_sel(off) != SEL_NONE) begin
        hit  = 1'b1;
        bank = BIDX_W'(b);
        sel  = off_to_sel(off);
      end
    end
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] lat_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR: dir_q <= wdata;
        SEL_LAT: lat_q <= wdata;
        SEL_SET: lat_q <= lat_q | wdata;
        SEL_CLR: lat_q <= lat_q & ~wdata;
        default: ;
      endcase
    end
  end

  // R4: every set bit lands in the latch on the next cycle
  a_r4_set_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_SET) |=> ((lat_q & $past(wdata)) == $past(wdata)));

  // R5: every cleared bit is zero on the next cycle, others untouched
  a_r5_clr_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CLR) |=>
      ((lat_q & $past(wdata)) == '0) &&
      ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));

  // R8: without a write to this bank nothing changes
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || sel == SEL_INP || sel == SEL_NONE) |=> ($stable(lat_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      dout   <= '0;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end

  // checker state: cycles since reset, saturating
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R7: synchronised value is the pin level from two edges earlier
  a_r7_two_flop_delay: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int BANK_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int TOTAL_W   = NUM_BANKS * BANK_W;
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              dec_hit;
  logic [BIDX_W-1:0] dec_bank;
  reg_sel_e          dec_sel;

  gpio_addr_dec #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_dec (
    .addr (bus_addr),
    .hit  (dec_hit),
    .bank (dec_bank),
    .sel  (dec_sel)
  );

  logic [TOTAL_W-1:0] pin_in_pad;
  logic [TOTAL_W-1:0] sync_all;
  logic [TOTAL_W-1:0] dir_all;
  logic [TOTAL_W-1:0] lat_all;

  assign pin_in_pad = TOTAL_W'(pin_in);

  gpio_in_sync #(.W(TOTAL_W)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in_pad),
    .dout (sync_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_we && dec_hit && (dec_bank == BIDX_W'(b));

    gpio_bank_regs #(.BANK_W(BANK_W)) u_regs (
      .clk   (clk),
      .rst   (rst),
      .wr_en (bank_wr),
      .sel   (dec_sel),
      .wdata (bus_wdata),
      .dir_q (dir_all[b*BANK_W +: BANK_W]),
      .lat_q (lat_all[b*BANK_W +: BANK_W])
    );
  end

  // valid-bit mask for the addressed bank (partial last bank reads zero above NUM_PINS)
  logic [TOTAL_W-1:0] pin_mask;
  assign pin_mask = {{(TOTAL_W-NUM_PINS){1'b0}}, {NUM_PINS{1'b1}}} ;

  logic [BANK_W-1:0] rd_val;
  always_comb begin
    logic [BANK_W-1:0] m;
    m = pin_mask[dec_bank*BANK_W +: BANK_W];
    case (dec_sel)
      SEL_DIR:                   rd_val = dir_all[dec_bank*BANK_W +: BANK_W] & m;
      SEL_LAT, SEL_SET, SEL_CLR: rd_val = lat_all[dec_bank*BANK_W +: BANK_W] & m;
      SEL_INP:                   rd_val = sync_all[dec_bank*BANK_W +: BANK_W] & m;
      default:                   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (dec_hit) bus_rdata <= rd_val;
    else              bus_rdata <= '0;
  end

  assign pin_out = lat_all[NUM_PINS-1:0];
  assign pin_oe  = ~dir_all[NUM_PINS-1:0];

  // R1: state straight out of reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && bus_rdata == '0));

  // R8: an access the decoder rejected returns zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(dec_hit) |-> (bus_rdata == '0));

  // R9: a write in the read cycle does not leak into that read
  a_r9_old_value: assert property (@(posedge clk) disable iff (rst)
    (bus_we && dec_hit && dec_sel == SEL_LAT) |=>
      (bus_rdata == $past(lat_all[dec_bank*BANK_W +: BANK_W] & pin_mask[dec_bank*BANK_W +: BANK_W])));

endmodule

// File: tb/gpio_bank_port_tb_top.sv
module gpio_bank_port_tb_top;

  localparam int NUM_PINS = 64;
  localparam int BANK_W   = 32;
  localparam int ADDR_W   = 8;

  logic                clk = 1'b0;
  logic                rst;
  logic [ADDR_W-1:0]   bus_addr;
  logic                bus_we;
  logic [BANK_W-1:0]   bus_wdata;
  logic [BANK_W-1:0]   bus_rdata;
  logic [NUM_PINS-1:0] pin_in;
  logic [NUM_PINS-1:0] pin_out;
  logic [NUM_PINS-1:0] pin_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_bank_port #(
    .NUM_PINS (NUM_PINS),
    .BANK_W   (BANK_W),
    .ADDR_W   (ADDR_W)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // bench model
  logic [31:0] m_dir [2];
  logic [31:0] m_lat [2];

  function automatic logic [7:0] a_of(input int bank, input int off);
    return 8'(16 + 40 * bank + off);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    for (int b = 0; b < 2; b++) begin
      if (a == a_of(b, 0))  return m_dir[b];
      if (a == a_of(b, 4))  return m_lat[b];
      if (a == a_of(b, 8))  return m_lat[b];
      if (a == a_of(b, 12)) return m_lat[b];
      if (a == a_of(b, 16)) return pin_in[b*32 +: 32];
    end
    return 32'h0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    for (int b = 0; b < 2; b++) begin
      if (a == a_of(b, 0))  m_dir[b] = d;
      if (a == a_of(b, 4))  m_lat[b] = d;
      if (a == a_of(b, 8))  m_lat[b] = m_lat[b] | d;
      if (a == a_of(b, 12)) m_lat[b] = m_lat[b] & ~d;
    end
  endtask

  task automatic check_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic idle(input int n);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic read_check(input string req, input logic [7:0] a);
    logic [31:0] d;
    bus_read(a, d);
    check_eq(req, $sformatf("read @%h", a), 64'(d), 64'(exp_read(a)));
  endtask

  task automatic pins_check(input string req);
    check_eq(req, "pin_oe",  64'(pin_oe),  ~{m_dir[1], m_dir[0]});
    check_eq(req, "pin_out", 64'(pin_out), {m_lat[1], m_lat[0]});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [7:0] unm [8];
    void'($urandom(32'h5eed_1234));
    unm[0] = 8'h00; unm[1] = 8'h0C; unm[2] = 8'h24; unm[3] = 8'h34;
    unm[4] = 8'h5C; unm[5] = 8'h60; unm[6] = 8'hB0; unm[7] = 8'h11;
    for (int b = 0; b < 2; b++) begin m_dir[b] = '1; m_lat[b] = '0; end

    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values during reset
    check_eq("R1", "rdata in reset", 64'(bus_rdata), 64'h0);
    pins_check("R1");
    rst = 1'b0;
    idle(1);
    pins_check("R1");
    read_check("R1", a_of(0, 0));
    read_check("R1", a_of(1, 4));

    // R2: bank 1 window address and pin p=40 -> bank 1 bit 8
    bus_write(a_of(1, 0), ~32'h0000_0100);
    pins_check("R2");
    check_eq("R2", "pin 40 enabled", 64'(pin_oe[40]), 64'h1);
    read_check("R2", a_of(1, 0));

    // R3/R4/R5/R6: latch ops with pins as inputs still drive pin_out
    bus_write(a_of(0, 4), 32'h1234_5678);
    pins_check("R3");
    bus_write(a_of(0, 8), 32'h8000_0001);
    read_check("R4", a_of(0, 4));
    check_eq("R4", "latch after set", 64'(pin_out[31:0]), 64'h9234_5679);
    bus_write(a_of(0, 12), 32'h0000_0078);
    read_check("R5", a_of(0, 8));
    check_eq("R5", "latch after clear", 64'(pin_out[31:0]), 64'h9234_5601);
    read_check("R6", a_of(0, 12));

    // R9: write and read same register in one cycle returns the old value
    bus_addr = a_of(1, 4); bus_we = 1'b1; bus_wdata = 32'hCAFE_F00D;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    check_eq("R9", "read during write", 64'(bus_rdata), 64'h0);
    model_write(a_of(1, 4), 32'hCAFE_F00D);
    read_check("R9", a_of(1, 4));

    // R7: pin change visible only after the third edge
    bus_addr = a_of(0, 16); bus_we = 1'b0;
    pin_in[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    check_eq("R7", "edge1", 64'(bus_rdata[5]), 64'h0);
    @(posedge clk); @(negedge clk);
    check_eq("R7", "edge2", 64'(bus_rdata[5]), 64'h0);
    @(posedge clk); @(negedge clk);
    check_eq("R7", "edge3", 64'(bus_rdata[5]), 64'h1);

    // R8: unmapped and input-offset writes are ignored
    for (int i = 0; i < 8; i++) begin
      bus_write(unm[i], 32'hFFFF_FFFF);
      read_check("R8", unm[i]);
    end
    bus_write(a_of(1, 16), 32'h0F0F_0F0F);
    read_check("R8", a_of(1, 0));
    read_check("R8", a_of(1, 4));
    read_check("R8", a_of(0, 0));
    read_check("R8", a_of(0, 4));
    pins_check("R8");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op; int bk; logic [31:0] dat; logic [7:0] ra;
      op  = int'($urandom % 8);
      bk  = int'($urandom % 2);
      dat = $urandom;
      case (op)
        0: bus_write(a_of(bk, 0), dat);
        1: bus_write(a_of(bk, 4), dat);
        2: bus_write(a_of(bk, 8), dat);
        3: bus_write(a_of(bk, 12), dat);
        4: bus_write(a_of(bk, 16), dat);
        5: bus_write(unm[$urandom % 8], dat);
        default: begin
          pin_in = {$urandom, $urandom};
          idle(2);
        end
      endcase
      pins_check("R3");
      if ($urandom % 4 == 0) ra = unm[$urandom % 8];
      else ra = a_of(int'($urandom % 2), 4 * int'($urandom % 5));
      read_check((op == 2) ? "R4" : (op == 3) ? "R5" : (op >= 6) ? "R7" : "R6", ra);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule